// File: doc/BRIEF.md
# DDR3 command decoder and bank tracker

This block sits on the device side of a DDR3-style command bus. On every rising clock edge it samples the chip select, the three command strobes (RAS#, CAS#, WE#), the bank address, the address bus and the clock enable. It turns them into one decoded command and keeps a model of the eight banks: whether each has an open row, and which row that is.

Mode-register writes are reported as a one-cycle strobe, together with the register index and the opcode. Auto-precharge requests on reads and writes are held until the access window closes. Precharge closes either one bank or all of them.

When the clock enable is sampled low, the block reports which power-down state applies. It also raises sticky flags when the command stream breaks a protocol rule. Every output is registered and changes one clock after the edge that sampled the command.

Top module: `ddr3_cmd_tracker`

## Requirements
- R1: With cs_n sampled high, the command is a deselect. cmd_code reads 0 and cmd_stb stays low one cycle later, whatever the other strobes are, and no bank changes state.
- R2: With cs_n low and cke high, {ras_n,cas_n,we_n} decode as follows: 011 ACTIVATE (code 2), 101 READ (3), 100 WRITE (4), 010 PRECHARGE (5), 000 MRS (6), 001 REFRESH (7), 111 NOP (1). Any other pattern decodes as NOP (1). The code appears on cmd_code one cycle after the sampling edge. cmd_stb is high for codes 2 to 7 only.
- R3: An ACTIVATE to an idle bank opens that bank. It stores addr[ROW_W-1:0] in the slice open_rows[ba*ROW_W +: ROW_W] and sets bank_open[ba].
- R4: An MRS pulses mrs_stb for one cycle. It loads mrs_idx with ba[1:0] and mrs_op with the full address bus. Both fields hold their value until the next MRS.
- R5: A READ or WRITE to an open bank with addr[10] low leaves the bank open. With addr[10] high, the bank closes ACC_CYC (default 4) edges after the command edge. Another READ or WRITE inside that window restarts the window.
- R6: A PRECHARGE with addr[10] low closes only bank ba. With addr[10] high it closes all banks.
- R7: One cycle after the sampling edge, pwr_state reads as follows: 0 when cke is high, 1 when cke is low and all banks are idle, 2 when cke is low and any bank is open. A command sampled with cke low is ignored and decodes as NOP (1).
- R8: cke sampled low while a read or write window is running sets err_cke.
- R9: A READ or WRITE to a closed bank, or an ACTIVATE to an open bank, sets err_proto and changes no bank state.
- R10: A REFRESH while any bank is open sets err_proto. A REFRESH with all banks idle does not.
- R11: Reset closes all banks, clears all stored rows, clears both error flags, sets cmd_code to 0 and sets pwr_state to 0. The error flags stay set until the next reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Command clock, rising edge samples |
| rst_n | input | 1 | Active-low synchronous reset |
| cke | input | 1 | Clock enable level |
| cs_n | input | 1 | Chip select, active low |
| ras_n | input | 1 | Row strobe |
| cas_n | input | 1 | Column strobe |
| we_n | input | 1 | Write strobe |
| ba | input | BANK_W | Bank address |
| addr | input | ADDR_W | Address / opcode bus |
| cmd_code | output | 3 | Registered decoded command |
| cmd_stb | output | 1 | High for one cycle per decoded action command |
| bank_open | output | 2**BANK_W | One bit per bank, high when a row is open |
| open_rows | output | 2**BANK_W*ROW_W | Stored row per bank, bank 0 in the low slice |
| mrs_stb | output | 1 | Mode-register write pulse |
| mrs_idx | output | 2 | Mode register selected by the last MRS |
| mrs_op | output | ADDR_W | Opcode of the last MRS |
| pwr_state | output | 2 | 0 active, 1 precharge power-down, 2 active power-down |
| err_proto | output | 1 | Sticky command-sequence error |
| err_cke | output | 1 | Sticky clock-enable-during-access error |

## Verification
The decoder is driven with every strobe pattern under both chip-select levels and both clock-enable levels. This separates a masked deselect from a power-down NOP and from a real command.

Bank tracking is tried with single-bank and all-bank precharges, and with auto-precharge accesses that are left to expire or are restarted by a second access. This shows whether the close happens on the exact edge and affects only the intended banks.

The clock enable is dropped with no bank open, with a bank open, and inside an access window. These three cases tell the two power-down kinds and the access error apart.

Random mixes of all commands under intermittent resets compare every output, each cycle, with a model built from the requirements.

// File: rtl/ddr3_trk_pkg.sv
package ddr3_trk_pkg;

   typedef enum logic [2:0] {
      CMD_DESEL = 3'd0,
      CMD_NOP   = 3'd1,
      CMD_ACT   = 3'd2,
      CMD_RD    = 3'd3,
      CMD_WR    = 3'd4,
      CMD_PRE   = 3'd5,
      CMD_MRS   = 3'd6,
      CMD_REF   = 3'd7
   } cmd_e;

   typedef enum logic [1:0] {
      PWR_ON     = 2'd0,
      PWR_PRE_PD = 2'd1,
      PWR_ACT_PD = 2'd2
   } pwr_e;

   // strobe patterns {ras_n, cas_n, we_n} with chip select asserted
   localparam logic [2:0] PAT_ACT = 3'b011;
   localparam logic [2:0] PAT_RD  = 3'b101;
   localparam logic [2:0] PAT_WR  = 3'b100;
   localparam logic [2:0] PAT_PRE = 3'b010;
   localparam logic [2:0] PAT_MRS = 3'b000;
   localparam logic [2:0] PAT_REF = 3'b001;

endpackage

// File: rtl/ddr3_cmd_decode.sv
module ddr3_cmd_decode
   import ddr3_trk_pkg::*;
(
   input  logic cs_n,
   input  logic ras_n,
   input  logic cas_n,
   input  logic we_n,
   input  logic cke,
   output cmd_e cmd
);

   always_comb begin
      if (cs_n) begin
         cmd = CMD_DESEL;
      end else if (!cke) begin
         cmd = CMD_NOP;
      end else begin
         case ({ras_n, cas_n, we_n})
            PAT_ACT: cmd = CMD_ACT;
            PAT_RD:  cmd = CMD_RD;
            PAT_WR:  cmd = CMD_WR;
            PAT_PRE: cmd = CMD_PRE;
            PAT_MRS: cmd = CMD_MRS;
            PAT_REF: cmd = CMD_REF;
            default: cmd = CMD_NOP;
         endcase
      end
   end

endmodule

// File: rtl/ddr3_access_timer.sv
module ddr3_access_timer #(
   parameter int ACC_CYC = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic load,
   output logic busy,
   output logic expire
);

   localparam int CW = $clog2(ACC_CYC + 1);

   logic [CW-1:0] cnt;

   assign busy   = (cnt != '0);
   assign expire = (cnt == CW'(1)) && !load;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cnt <= '0;
      end else if (load) begin
         cnt <= CW'(ACC_CYC);
      end else if (busy) begin
         cnt <= cnt - CW'(1);
      end
   end

endmodule

// File: rtl/ddr3_bank_slot.sv
module ddr3_bank_slot #(
   parameter int ROW_W     = 16,
   parameter bit TRACK_ROW = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             act,
   input  logic             close,
   input  logic             set_ap,
   input  logic             ap_fire,
   input  logic [ROW_W-1:0] row_in,
   output logic             is_open,
   output logic [ROW_W-1:0] row_q
);

   logic ap_pend;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         is_open <= 1'b0;
         ap_pend <= 1'b0;
      end else if (act) begin
         is_open <= 1'b1;
         ap_pend <= 1'b0;
      end else if (close || (ap_fire && ap_pend)) begin
         is_open <= 1'b0;
         ap_pend <= 1'b0;
      end else if (set_ap) begin
         ap_pend <= 1'b1;
      end
   end

   generate
      if (TRACK_ROW) begin : g_row
         always_ff @(posedge clk) begin
            if (!rst_n) begin
               row_q <= '0;
            end else if (act) begin
               row_q <= row_in;
            end
         end
      end else begin : g_norow
         assign row_q = '0;
      end
   endgenerate

endmodule

// File: rtl/ddr3_cmd_tracker.sv
module ddr3_cmd_tracker
   import ddr3_trk_pkg::*;
#(
   parameter int BANK_W    = 3,
   parameter int ADDR_W    = 16,
   parameter int ROW_W     = 16,
   parameter int AP_BIT    = 10,
   parameter int ACC_CYC   = 4,
   parameter bit TRACK_ROW = 1'b1
) (
   input  logic                              clk,
   input  logic                              rst_n,
   input  logic                              cke,
   input  logic                              cs_n,
   input  logic                              ras_n,
   input  logic                              cas_n,
   input  logic                              we_n,
   input  logic [BANK_W-1:0]                 ba,
   input  logic [ADDR_W-1:0]                 addr,
   output logic [2:0]                        cmd_code,
   output logic                              cmd_stb,
   output logic [(1<<BANK_W)-1:0]            bank_open,
   output logic [(1<<BANK_W)*ROW_W-1:0]      open_rows,
   output logic                              mrs_stb,
   output logic [1:0]                        mrs_idx,
   output logic [ADDR_W-1:0]                 mrs_op,
   output logic [1:0]                        pwr_state,
   output logic                              err_proto,
   output logic                              err_cke
);

   localparam int NB = 1 << BANK_W;

   // elaboration-time parameter checks
   generate
      if (BANK_W < 2 || BANK_W > 4) begin : g_bad_bank
         $error("BANK_W must be 2..4");
      end
      if (AP_BIT >= ADDR_W) begin : g_bad_ap
         $error("AP_BIT must index the address bus");
      end
      if (ROW_W > ADDR_W || ROW_W < 1) begin : g_bad_row
         $error("ROW_W must fit the address bus");
      end
      if (ACC_CYC < 1) begin : g_bad_acc
         $error("ACC_CYC must be at least 1");
      end
   endgenerate

   cmd_e          cmd;
   logic [NB-1:0] open_w;
   logic          any_open;
   logic          hit;
   logic          is_rw;
   logic          rw_ok;
   logic          act_ok;
   logic          proto_bad;
   logic          ap_flag;
   logic          acc_busy;
   logic          acc_expire;

   ddr3_cmd_decode i_decode (
      .cs_n  (cs_n),
      .ras_n (ras_n),
      .cas_n (cas_n),
      .we_n  (we_n),
      .cke   (cke),
      .cmd   (cmd)
   );

   assign any_open  = |open_w;
   assign hit       = open_w[ba];
   assign is_rw     = (cmd == CMD_RD) || (cmd == CMD_WR);
   assign rw_ok     = is_rw && hit;
   assign act_ok    = (cmd == CMD_ACT) && !hit;
   assign ap_flag   = addr[AP_BIT];
   assign proto_bad = ((cmd == CMD_ACT) && hit) ||
                      (is_rw && !hit) ||
                      ((cmd == CMD_REF) && any_open);

   ddr3_access_timer #(.ACC_CYC(ACC_CYC)) i_timer (
      .clk    (clk),
      .rst_n  (rst_n),
      .load   (rw_ok),
      .busy   (acc_busy),
      .expire (acc_expire)
   );

   generate
      for (genvar gi = 0; gi < NB; gi++) begin : g_bank
         logic sel;
         assign sel = (ba == BANK_W'(gi));

         ddr3_bank_slot #(
            .ROW_W     (ROW_W),
            .TRACK_ROW (TRACK_ROW)
         ) i_slot (
            .clk     (clk),
            .rst_n   (rst_n),
            .act     (act_ok && sel),
            .close   ((cmd == CMD_PRE) && (ap_flag || sel)),
            .set_ap  (rw_ok && sel && ap_flag),
            .ap_fire (acc_expire),
            .row_in  (addr[ROW_W-1:0]),
            .is_open (open_w[gi]),
            .row_q   (open_rows[gi*ROW_W +: ROW_W])
         );
      end
   endgenerate

   assign bank_open = open_w;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cmd_code  <= CMD_DESEL;
         cmd_stb   <= 1'b0;
         mrs_stb   <= 1'b0;
         mrs_idx   <= '0;
         mrs_op    <= '0;
         pwr_state <= PWR_ON;
         err_proto <= 1'b0;
         err_cke   <= 1'b0;
      end else begin
         cmd_code  <= cmd;
         cmd_stb   <= (cmd != CMD_DESEL) && (cmd != CMD_NOP);
         mrs_stb   <= (cmd == CMD_MRS);
         if (cmd == CMD_MRS) begin
            mrs_idx <= ba[1:0];
            mrs_op  <= addr;
         end
         if (cke) begin
            pwr_state <= PWR_ON;
         end else if (any_open) begin
            pwr_state <= PWR_ACT_PD;
         end else begin
            pwr_state <= PWR_PRE_PD;
         end
         err_proto <= err_proto | proto_bad;
         err_cke   <= err_cke | (!cke && acc_busy);
      end
   end

endmodule

// File: rtl/ddr3_cmd_tracker_chk.sv
module ddr3_cmd_tracker_chk #(
   parameter int BANK_W = 3,
   parameter int ADDR_W = 16,
   parameter int AP_BIT = 10
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   cke,
   input logic                   cs_n,
   input logic                   ras_n,
   input logic                   cas_n,
   input logic                   we_n,
   input logic [BANK_W-1:0]      ba,
   input logic [ADDR_W-1:0]      addr,
   input logic [2:0]             cmd_code,
   input logic                   cmd_stb,
   input logic [(1<<BANK_W)-1:0] bank_open,
   input logic                   mrs_stb,
   input logic [1:0]             mrs_idx,
   input logic [ADDR_W-1:0]      mrs_op,
   input logic [1:0]             pwr_state,
   input logic                   err_proto,
   input logic                   err_cke
);

   logic live;
   logic [2:0] pat;
   assign live = !cs_n && cke;
   assign pat  = {ras_n, cas_n, we_n};

   assert_desel_R1: assert property (@(posedge clk) disable iff (!rst_n)
      cs_n |=> (cmd_code == 3'd0 && !cmd_stb));

   assert_mrs_strobe_R2: assert property (@(posedge clk) disable iff (!rst_n)
      mrs_stb |-> (cmd_stb && cmd_code == 3'd6));

   assert_act_opens_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (live && pat == 3'b011 && !bank_open[ba]) |=> bank_open[$past(ba)]);

   assert_mrs_fields_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (live && pat == 3'b000) |=>
         (mrs_stb && mrs_idx == $past(ba[1:0]) && mrs_op == $past(addr)));

   assert_pre_all_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (live && pat == 3'b010 && addr[AP_BIT]) |=> (bank_open == '0));

   assert_pd_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke && bank_open == '0) |=> (pwr_state == 2'd1));

   assert_pd_active_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (!cke && bank_open != '0) |=> (pwr_state == 2'd2));

   assert_pwr_on_R7: assert property (@(posedge clk) disable iff (!rst_n)
      cke |=> (pwr_state == 2'd0));

   assert_rw_closed_R9: assert property (@(posedge clk) disable iff (!rst_n)
      (live && (pat == 3'b101 || pat == 3'b100) && !bank_open[ba]) |=> err_proto);

   assert_ref_open_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (live && pat == 3'b001 && bank_open != '0) |=> err_proto);

   assert_proto_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err_proto |=> err_proto);

   assert_cke_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
      err_cke |=> err_cke);

endmodule

bind ddr3_cmd_tracker ddr3_cmd_tracker_chk #(
   .BANK_W (BANK_W),
   .ADDR_W (ADDR_W),
   .AP_BIT (AP_BIT)
) i_ddr3_cmd_tracker_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .cke       (cke),
   .cs_n      (cs_n),
   .ras_n     (ras_n),
   .cas_n     (cas_n),
   .we_n      (we_n),
   .ba        (ba),
   .addr      (addr),
   .cmd_code  (cmd_code),
   .cmd_stb   (cmd_stb),
   .bank_open (bank_open),
   .mrs_stb   (mrs_stb),
   .mrs_idx   (mrs_idx),
   .mrs_op    (mrs_op),
   .pwr_state (pwr_state),
   .err_proto (err_proto),
   .err_cke   (err_cke)
);

// File: tb/test_ddr3_cmd_tracker.sv
`timescale 1ns/1ps
module test_ddr3_cmd_tracker;

   localparam int ACC = 4;
   localparam logic [2:0] K_ACT = 3'b011;
   localparam logic [2:0] K_RD  = 3'b101;
   localparam logic [2:0] K_WR  = 3'b100;
   localparam logic [2:0] K_PRE = 3'b010;
   localparam logic [2:0] K_MRS = 3'b000;
   localparam logic [2:0] K_REF = 3'b001;
   localparam logic [2:0] K_NOP = 3'b111;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic cke = 1'b1;
   logic cs_n = 1'b1;
   logic ras_n = 1'b1, cas_n = 1'b1, we_n = 1'b1;
   logic [2:0]  ba = '0;
   logic [15:0] addr = '0;

   logic [2:0]   cmd_code;
   logic         cmd_stb;
   logic [7:0]   bank_open;
   logic [127:0] open_rows;
   logic         mrs_stb;
   logic [1:0]   mrs_idx;
   logic [15:0]  mrs_op;
   logic [1:0]   pwr_state;
   logic         err_proto, err_cke;

   int n_chk = 0;
   int n_fail = 0;

   // reference model state
   logic [7:0]  m_open, m_ap;
   logic [15:0] m_row [8];
   int          m_cnt;
   logic        m_errp, m_errc, m_stb, m_mrs;
   logic [2:0]  m_cmd;
   logic [1:0]  m_idx, m_pwr;
   logic [15:0] m_op;

   always #2.5 clk = ~clk;

   ddr3_cmd_tracker i_ddr3_cmd_tracker (
      .clk(clk), .rst_n(rst_n), .cke(cke), .cs_n(cs_n), .ras_n(ras_n),
      .cas_n(cas_n), .we_n(we_n), .ba(ba), .addr(addr),
      .cmd_code(cmd_code), .cmd_stb(cmd_stb), .bank_open(bank_open),
      .open_rows(open_rows), .mrs_stb(mrs_stb), .mrs_idx(mrs_idx),
      .mrs_op(mrs_op), .pwr_state(pwr_state), .err_proto(err_proto),
      .err_cke(err_cke)
   );

   function automatic logic [2:0] decode_f(logic c, logic [2:0] p, logic k);
      if (c) return 3'd0;
      if (!k) return 3'd1;
      case (p)
         K_ACT: return 3'd2;
         K_RD:  return 3'd3;
         K_WR:  return 3'd4;
         K_PRE: return 3'd5;
         K_MRS: return 3'd6;
         K_REF: return 3'd7;
         default: return 3'd1;
      endcase
   endfunction

   task automatic model_reset();
      m_open = '0; m_ap = '0; m_cnt = 0;
      for (int i = 0; i < 8; i++) m_row[i] = '0;
      m_errp = 0; m_errc = 0; m_stb = 0; m_mrs = 0;
      m_cmd = 3'd0; m_idx = '0; m_op = '0; m_pwr = 2'd0;
   endtask

   task automatic model_step();
      logic [2:0] c;
      logic any, hit, rw, rwok, actok, fire, a10;
      c     = decode_f(cs_n, {ras_n, cas_n, we_n}, cke);
      any   = |m_open;
      hit   = m_open[ba];
      rw    = (c == 3'd3) || (c == 3'd4);
      rwok  = rw && hit;
      actok = (c == 3'd2) && !hit;
      fire  = (m_cnt == 1) && !rwok;
      a10   = addr[10];
      if ((c == 3'd2 && hit) || (rw && !hit) || (c == 3'd7 && any)) m_errp = 1;
      if (!cke && m_cnt != 0) m_errc = 1;
      if (rwok) m_cnt = ACC;
      else if (m_cnt != 0) m_cnt = m_cnt - 1;
      m_pwr = cke ? 2'd0 : (any ? 2'd2 : 2'd1);
      for (int i = 0; i < 8; i++) begin
         if (actok && ba == 3'(i)) begin
            m_open[i] = 1; m_row[i] = addr; m_ap[i] = 0;
         end else if (c == 3'd5 && (a10 || ba == 3'(i))) begin
            m_open[i] = 0; m_ap[i] = 0;
         end else if (fire && m_ap[i]) begin
            m_open[i] = 0; m_ap[i] = 0;
         end else if (rwok && ba == 3'(i) && a10) begin
            m_ap[i] = 1;
         end
      end
      m_cmd = c;
      m_stb = (c >= 3'd2);
      m_mrs = (c == 3'd6);
      if (c == 3'd6) begin
         m_idx = ba[1:0]; m_op = addr;
      end
   endtask

   task automatic chk(input string tag, input string what,
                      input logic [127:0] got, input logic [127:0] exp);
      n_chk++;
      if (got !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", tag, what, got, exp);
      end
   endtask

   task automatic compare_all();
      logic [127:0] rows;
      for (int i = 0; i < 8; i++) rows[i*16 +: 16] = m_row[i];
      chk("R2", "cmd_code", 128'(cmd_code), 128'(m_cmd));
      chk("R2", "cmd_stb", 128'(cmd_stb), 128'(m_stb));
      chk("R6", "bank_open", 128'(bank_open), 128'(m_open));
      chk("R3", "open_rows", open_rows, rows);
      chk("R4", "mrs_stb", 128'(mrs_stb), 128'(m_mrs));
      chk("R4", "mrs_fields", 128'({mrs_idx, mrs_op}), 128'({m_idx, m_op}));
      chk("R7", "pwr_state", 128'(pwr_state), 128'(m_pwr));
      chk("R8", "err_cke", 128'(err_cke), 128'(m_errc));
      chk("R9", "err_proto", 128'(err_proto), 128'(m_errp));
   endtask

   // drive at a falling edge, let one rising edge sample, compare at next falling edge
   task automatic cyc(input logic c, input logic [2:0] p, input logic [2:0] b,
                      input logic [15:0] a, input logic k);
      cs_n = c; {ras_n, cas_n, we_n} = p; ba = b; addr = a; cke = k;
      @(posedge clk);
      model_step();
      @(negedge clk);
      compare_all();
   endtask

   task automatic do_reset();
      rst_n = 0; cs_n = 1; cke = 1; {ras_n, cas_n, we_n} = K_NOP;
      repeat (2) @(posedge clk);
      model_reset();
      @(negedge clk);
      rst_n = 1;
      compare_all();
      chk("R11", "reset bank_open", 128'(bank_open), 128'(0));
      chk("R11", "reset errors", 128'({err_proto, err_cke}), 128'(0));
      chk("R11", "reset pwr/cmd", 128'({pwr_state, cmd_code}), 128'(0));
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      void'($urandom(32'd2024));
      model_reset();
      @(negedge clk);
      do_reset();

      // R1: deselect masks an activate pattern
      cyc(1, K_ACT, 3'd2, 16'h0055, 1);
      chk("R1", "deselect code", 128'(cmd_code), 128'(0));
      chk("R1", "deselect no open", 128'(bank_open[2]), 128'(0));

      // R3 / R5: activate then auto-precharge read
      cyc(0, K_ACT, 3'd3, 16'h1234, 1);
      chk("R3", "row bank3", 128'(open_rows[48 +: 16]), 128'(16'h1234));
      cyc(0, K_RD, 3'd3, 16'h0400, 1);
      for (int i = 0; i < ACC - 1; i++) begin
         cyc(0, K_NOP, 3'd0, 16'h0, 1);
         chk("R5", "ap still open", 128'(bank_open[3]), 128'(1));
      end
      cyc(0, K_NOP, 3'd0, 16'h0, 1);
      chk("R5", "ap closed", 128'(bank_open[3]), 128'(0));

      // R5: restart of the window by a second access
      cyc(0, K_ACT, 3'd5, 16'h00aa, 1);
      cyc(0, K_WR, 3'd5, 16'h0400, 1);
      cyc(0, K_NOP, 3'd0, 16'h0, 1);
      cyc(0, K_RD, 3'd5, 16'h0000, 1);
      for (int i = 0; i < ACC - 1; i++) cyc(0, K_NOP, 3'd0, 16'h0, 1);
      chk("R5", "restart open", 128'(bank_open[5]), 128'(1));
      cyc(0, K_NOP, 3'd0, 16'h0, 1);
      chk("R5", "restart closed", 128'(bank_open[5]), 128'(0));

      // R6: single and all-bank precharge
      cyc(0, K_ACT, 3'd1, 16'h0011, 1);
      cyc(0, K_ACT, 3'd2, 16'h0022, 1);
      cyc(0, K_PRE, 3'd1, 16'h0000, 1);
      chk("R6", "single precharge", 128'(bank_open), 128'(8'b0000_0100));
      cyc(0, K_ACT, 3'd7, 16'h0077, 1);
      cyc(0, K_PRE, 3'd0, 16'h0400, 1);
      chk("R6", "precharge all", 128'(bank_open), 128'(0));

      // R4: mode register write
      cyc(0, K_MRS, 3'd2, 16'hbeef, 1);
      chk("R4", "mrs idx/op", 128'({mrs_stb, mrs_idx, mrs_op}), 128'({1'b1, 2'd2, 16'hbeef}));

      // R7: power-down kinds and ignored command
      cyc(0, K_NOP, 3'd0, 16'h0, 0);
      chk("R7", "precharge pd", 128'(pwr_state), 128'(1));
      cyc(0, K_ACT, 3'd4, 16'h0044, 0);
      chk("R7", "ignored act", 128'({cmd_code, bank_open[4]}), 128'({3'd1, 1'b0}));
      cyc(0, K_ACT, 3'd0, 16'h0100, 1);
      cyc(0, K_NOP, 3'd0, 16'h0, 0);
      chk("R7", "active pd", 128'(pwr_state), 128'(2));
      chk("R8", "no access no err", 128'(err_cke), 128'(0));

      // R8: cke drop inside an access window
      cyc(0, K_RD, 3'd0, 16'h0000, 1);
      cyc(0, K_NOP, 3'd0, 16'h0, 0);
      chk("R8", "cke during access", 128'(err_cke), 128'(1));

      // R9 / R10 / R11
      do_reset();
      cyc(0, K_REF, 3'd0, 16'h0, 1);
      chk("R10", "refresh idle ok", 128'(err_proto), 128'(0));
      cyc(0, K_WR, 3'd2, 16'h0, 1);
      chk("R9", "write closed", 128'({err_proto, bank_open[2]}), 128'({1'b1, 1'b0}));
      do_reset();
      cyc(0, K_ACT, 3'd6, 16'h0066, 1);
      cyc(0, K_REF, 3'd0, 16'h0, 1);
      chk("R10", "refresh open err", 128'(err_proto), 128'(1));
      for (int i = 0; i < 5; i++) cyc(0, K_NOP, 3'd0, 16'h0, 1);
      chk("R11", "sticky err", 128'(err_proto), 128'(1));

      // random mixes under periodic reset
      for (int blk = 0; blk < 4; blk++) begin
         do_reset();
         for (int n = 0; n < 700; n++) begin
            logic [2:0] p;
            case ($urandom % 8)
               0, 7: p = K_ACT;
               1: p = K_RD;
               2: p = K_WR;
               3: p = K_PRE;
               4: p = K_MRS;
               5: p = K_REF;
               default: p = 3'($urandom);
            endcase
            cyc(($urandom % 100) < 8, p, 3'($urandom), 16'($urandom),
                ($urandom % 10) != 0);
         end
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule